// File: doc/BRIEF.md
# Multi-mode effective address generator

This block turns one addressing request into a memory effective address. A request carries a mode code, the values read from the base and index registers, a 16-bit constant taken from the instruction word, and an operand size. From these the block forms the address the load/store unit should use. For the auto-modify modes it also produces the new base register value and a write-back strobe for the register file.

Register and immediate operands need no memory access, so for those modes the block reports that no address is produced. A mode code outside the defined set raises an illegal-mode flag and suppresses both the address and the write-back.

All outputs are registered and appear exactly one clock after the request is presented. Deferred (double) indirection, the register file and the memory are outside the block.

Top module: `ea_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, addrValid, wbEn and illegalMode are 0, and addrOut and wbValue are 0.
- R2: Displacement mode (code 2) yields addrOut = base + constant sign-extended from 16 to 32 bits, with addrValid = 1.
- R3: Register indirect mode (code 3) yields addrOut = base, which is displacement with a zero constant.
- R4: Indexed mode (code 4) yields addrOut = base + index.
- R5: Absolute mode (code 5) yields addrOut = the sign-extended constant; the base and index values have no effect.
- R6: Pre-decrement mode (code 6) yields addrOut = base − step and wbValue = base − step with wbEn = 1. The step is 1, 2, 4 or 8 bytes for opSize 0, 1, 2 or 3, and arithmetic wraps modulo 2^32.
- R7: Post-increment mode (code 7) yields addrOut = base (the unmodified value), wbValue = base + step and wbEn = 1.
- R8: Scaled mode (code 8) yields addrOut = base + index × 2^opSize + sign-extended constant, so halfword, word and doubleword sizes scale by 2, 4 and 8.
- R9: Register mode (code 0) and immediate mode (code 1) give addrValid = 0, wbEn = 0, illegalMode = 0 and addrOut = 0.
- R10: Mode codes 9 to 15 give illegalMode = 1, addrValid = 0 and wbEn = 0.
- R11: wbEn is 1 only for modes 6 and 7, for exactly one cycle per accepted request. Whenever wbEn is 0, wbValue is 0.
- R12: Outputs reflect the request sampled at the previous rising edge. When reqValid is 0, all three flags are 0 in the next cycle and addrOut and wbValue are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present this cycle |
| modeSel | input | 4 | Addressing mode code |
| baseVal | input | 32 | Base register value |
| indexVal | input | 32 | Index register value |
| constVal | input | 16 | Instruction constant field |
| opSize | input | 2 | Operand size, log2 of bytes |
| addrOut | output | 32 | Effective address |
| addrValid | output | 1 | addrOut holds a memory address |
| wbValue | output | 32 | Updated base register value |
| wbEn | output | 1 | Write wbValue back to the base register |
| illegalMode | output | 1 | Mode code was not recognised |

## Verification
The bench builds the block with its default widths: a 32-bit address and a 16-bit constant. The 16-bit constant lets directed cases reach both sign-extension polarities, including 0x8000 and 0xFFFF. The 32-bit address makes wraparound visible at the extremes, for example pre-decrement from a base of 0 and post-increment from 0xFFFFFFFF. Random requests then cover every mode code, including all illegal ones, at every operand size, interleaved with idle cycles.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_REG     = 4'd0,
    MODE_IMM     = 4'd1,
    MODE_DISP    = 4'd2,
    MODE_IND     = 4'd3,
    MODE_IDX     = 4'd4,
    MODE_ABS     = 4'd5,
    MODE_PREDEC  = 4'd6,
    MODE_POSTINC = 4'd7,
    MODE_SCALED  = 4'd8
  } eaMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic useBase;
    logic useIndex;
    logic useConst;
    logic scaleIndex;
    logic modifyBase;
    logic stepDown;
    logic preModify;
    logic memAccess;
    logic badMode;
  } eaStrobes_t;
endpackage

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
(
  input  logic              reqValid,
  input  logic [MODE_W-1:0] modeSel,
  output eaStrobes_t        strobes
);
  always_comb begin
    strobes = '0;
    if (reqValid) begin
      case (modeSel)
        MODE_REG, MODE_IMM: ; // operand comes from a register or the instruction
        MODE_DISP: begin
          strobes.useBase   = 1'b1;
          strobes.useConst  = 1'b1;
          strobes.memAccess = 1'b1;
        end
        MODE_IND: begin
          strobes.useBase   = 1'b1;
          strobes.memAccess = 1'b1;
        end
        MODE_IDX: begin
          strobes.useBase   = 1'b1;
          strobes.useIndex  = 1'b1;
          strobes.memAccess = 1'b1;
        end
        MODE_ABS: begin
          strobes.useConst  = 1'b1;
          strobes.memAccess = 1'b1;
        end
        MODE_PREDEC: begin
          strobes.modifyBase = 1'b1;
          strobes.stepDown   = 1'b1;
          strobes.preModify  = 1'b1;
          strobes.memAccess  = 1'b1;
        end
        MODE_POSTINC: begin
          strobes.useBase    = 1'b1;
          strobes.modifyBase = 1'b1;
          strobes.memAccess  = 1'b1;
        end
        MODE_SCALED: begin
          strobes.useBase    = 1'b1;
          strobes.useIndex   = 1'b1;
          strobes.useConst   = 1'b1;
          strobes.scaleIndex = 1'b1;
          strobes.memAccess  = 1'b1;
        end
        default: strobes.badMode = 1'b1;
      endcase
    end
  end

  // exclusive outcomes per request: R10 / R11
  always_comb begin
    if (strobes.badMode) assert (!strobes.memAccess && !strobes.modifyBase)
      else $error("p_bad_mode_exclusive_r10");
  end
endmodule

// File: rtl/ea_datapath.sv
module ea_datapath
  import ea_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CONST_W = 16,
  parameter int SIZE_W  = 2
)(
  input  logic               clk,
  input  logic               rst_n,
  input  eaStrobes_t         strobes,
  input  logic [ADDR_W-1:0]  baseVal,
  input  logic [ADDR_W-1:0]  indexVal,
  input  logic [CONST_W-1:0] constVal,
  input  logic [SIZE_W-1:0]  opSize,
  output logic [ADDR_W-1:0]  addrOut,
  output logic               addrValid,
  output logic [ADDR_W-1:0]  wbValue,
  output logic               wbEn,
  output logic               illegalMode
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] constExt;
  logic [ADDR_W-1:0] stepBytes, scaledIdx;
  logic [ADDR_W-1:0] termA, termB, termC;
  logic [ADDR_W-1:0] sumAddr, modifiedBase, addrNext;

  generate
    if (ADDR_W > CONST_W) begin : g_sext
      assign constExt = {{(ADDR_W-CONST_W){constVal[CONST_W-1]}}, constVal};
    end else begin : g_trunc
      assign constExt = constVal[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    stepBytes    = ONE << opSize;
    scaledIdx    = strobes.scaleIndex ? (indexVal << opSize) : indexVal;
    termA        = strobes.useBase  ? baseVal   : '0;
    termB        = strobes.useIndex ? scaledIdx : '0;
    termC        = strobes.useConst ? constExt  : '0;
    sumAddr      = termA + termB + termC;
    modifiedBase = strobes.stepDown ? (baseVal - stepBytes) : (baseVal + stepBytes);
    addrNext     = strobes.preModify ? modifiedBase : sumAddr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addrOut     <= '0;
      addrValid   <= 1'b0;
      wbValue     <= '0;
      wbEn        <= 1'b0;
      illegalMode <= 1'b0;
    end else begin
      addrOut     <= strobes.memAccess  ? addrNext     : '0;
      addrValid   <= strobes.memAccess;
      wbValue     <= strobes.modifyBase ? modifiedBase : '0;
      wbEn        <= strobes.modifyBase;
      illegalMode <= strobes.badMode;
    end
  end

  p_wb_needs_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wbEn |-> addrValid);
  p_wbvalue_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wbEn |-> (wbValue == '0));
  p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    illegalMode |-> (!addrValid && !wbEn));
  p_addr_zero_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !addrValid |-> (addrOut == '0));
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CONST_W = 16
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reqValid,
  input  logic [3:0]         modeSel,
  input  logic [ADDR_W-1:0]  baseVal,
  input  logic [ADDR_W-1:0]  indexVal,
  input  logic [CONST_W-1:0] constVal,
  input  logic [1:0]         opSize,
  output logic [ADDR_W-1:0]  addrOut,
  output logic               addrValid,
  output logic [ADDR_W-1:0]  wbValue,
  output logic               wbEn,
  output logic               illegalMode
);
  eaStrobes_t strobes;

  ea_ctrl ctrl_i (
    .reqValid (reqValid),
    .modeSel  (modeSel),
    .strobes  (strobes)
  );

  ea_datapath #(.ADDR_W(ADDR_W), .CONST_W(CONST_W), .SIZE_W(2)) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .baseVal     (baseVal),
    .indexVal    (indexVal),
    .constVal    (constVal),
    .opSize      (opSize),
    .addrOut     (addrOut),
    .addrValid   (addrValid),
    .wbValue     (wbValue),
    .wbEn        (wbEn),
    .illegalMode (illegalMode)
  );

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> (!addrValid && !wbEn && !illegalMode));
  p_no_addr_regimm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && modeSel <= 4'd1) |=> (!addrValid && !wbEn && !illegalMode));
  p_wb_only_automod_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && modeSel != 4'd6 && modeSel != 4'd7) |=> !wbEn);
  p_ind_is_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && modeSel == 4'd3) |=> (addrValid && addrOut == $past(baseVal)));
  p_illegal_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && modeSel > 4'd8) |=> illegalMode);
endmodule

// File: tb/ea_gen_tb_top.sv
module ea_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [3:0]  modeSel = '0;
  logic [31:0] baseVal = '0, indexVal = '0;
  logic [15:0] constVal = '0;
  logic [1:0]  opSize = '0;
  logic [31:0] addrOut, wbValue;
  logic        addrValid, wbEn, illegalMode;

  int compared = 0, mismatched = 0;
  logic [31:0] eAddr = '0, eWb = '0;
  logic eValid = 1'b0, eWbEn = 1'b0, eIll = 1'b0;
  string eTag = "R1";

  always #10 clk = ~clk; // 50 MHz

  ea_gen dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .modeSel(modeSel),
    .baseVal(baseVal), .indexVal(indexVal), .constVal(constVal), .opSize(opSize),
    .addrOut(addrOut), .addrValid(addrValid), .wbValue(wbValue), .wbEn(wbEn),
    .illegalMode(illegalMode)
  );

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    cmp(eTag, "addrOut", addrOut, eAddr);
    cmp(eTag, "addrValid", {31'b0, addrValid}, {31'b0, eValid});
    cmp(eTag, "wbValue", wbValue, eWb);
    cmp(eTag, "wbEn", {31'b0, wbEn}, {31'b0, eWbEn});
    cmp(eTag, "illegalMode", {31'b0, illegalMode}, {31'b0, eIll});
  endtask

  // behavioural reference, written from the requirements
  task automatic predict(logic v, logic [3:0] m, logic [31:0] b, logic [31:0] x,
                         logic [15:0] c, logic [1:0] sz);
    logic [31:0] sc = {{16{c[15]}}, c};
    logic [31:0] st = 32'd1 << sz;
    eAddr = 0; eWb = 0; eValid = 0; eWbEn = 0; eIll = 0;
    if (!v) begin eTag = "R12"; return; end
    case (m)
      0, 1: eTag = "R9";
      2: begin eTag = "R2"; eValid = 1; eAddr = b + sc; end
      3: begin eTag = "R3"; eValid = 1; eAddr = b; end
      4: begin eTag = "R4"; eValid = 1; eAddr = b + x; end
      5: begin eTag = "R5"; eValid = 1; eAddr = sc; end
      6: begin eTag = "R6"; eValid = 1; eAddr = b - st; eWb = b - st; eWbEn = 1; end
      7: begin eTag = "R7"; eValid = 1; eAddr = b; eWb = b + st; eWbEn = 1; end
      8: begin eTag = "R8"; eValid = 1; eAddr = b + x * st + sc; end
      default: begin eTag = "R10"; eIll = 1; end
    endcase
  endtask

  // check the previous request's result, then present a new one
  task automatic step(logic v, logic [3:0] m, logic [31:0] b, logic [31:0] x,
                      logic [15:0] c, logic [1:0] sz);
    @(negedge clk);
    compareAll();
    predict(v, m, b, x, c, sz);
    reqValid = v; modeSel = m; baseVal = b; indexVal = x; constVal = c; opSize = sz;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1: reset state, including inputs active during reset
    reqValid = 1; modeSel = 4'd6; baseVal = 32'h100;
    repeat (3) begin @(negedge clk); eTag = "R1"; compareAll(); end
    @(negedge clk); rst_n = 1'b1; reqValid = 0;
    eTag = "R1";
    step(0, 0, 0, 0, 0, 0);
    // directed cases
    step(1, 2, 32'h1000, 0, 16'h0010, 0);          // R2 positive
    step(1, 2, 32'h1000, 0, 16'hFFF0, 0);          // R2 negative
    step(1, 2, 32'h0, 0, 16'h8000, 0);             // R2 most negative
    step(1, 3, 32'hDEADBEEF, 32'h5, 16'h1234, 3);  // R3
    step(1, 4, 32'h100, 32'h20, 16'h7, 0);         // R4
    step(1, 4, 32'hFFFFFFFF, 32'h2, 0, 0);         // R4 wrap
    step(1, 5, 32'h55555555, 32'h1, 16'hFFFF, 2);  // R5 negative
    step(1, 5, 32'h1, 32'h1, 16'h7FFF, 0);         // R5 positive
    for (int s = 0; s < 4; s++) step(1, 6, 32'h200, 0, 0, 2'(s)); // R6
    step(1, 6, 32'h0, 0, 0, 3);                    // R6 wrap below zero
    for (int s = 0; s < 4; s++) step(1, 7, 32'h300, 0, 0, 2'(s)); // R7
    step(1, 7, 32'hFFFFFFFF, 0, 0, 0);             // R7 wrap
    for (int s = 0; s < 4; s++) step(1, 8, 32'h1000, 32'h3, 16'hFFFC, 2'(s)); // R8
    step(1, 0, 32'h1, 32'h2, 16'h3, 1);            // R9 register
    step(1, 1, 32'h1, 32'h2, 16'h3, 1);            // R9 immediate
    for (int m = 9; m < 16; m++) step(1, 4'(m), 32'h40, 32'h4, 16'h4, 1); // R10
    step(1, 6, 32'h80, 0, 0, 1);                   // R11 pulse then idle
    step(0, 6, 32'h80, 0, 0, 1);                   // R12 idle mode ignored
    step(1, 7, 32'h80, 0, 0, 1);
    step(1, 7, 32'h90, 0, 0, 2);                   // back-to-back R11
    // random mix
    for (int i = 0; i < 3000; i++)
      step(($urandom % 5) != 0, 4'($urandom), $urandom, $urandom,
           16'($urandom), 2'($urandom));
    step(0, 0, 0, 0, 0, 0);
    @(negedge clk); compareAll();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule